// File: doc/BRIEF.md
# Debug Register Access Permission Gate

This block sits between an APB slave port and a bank of debug registers. For every transfer it decides whether to forward the access to the bank, to drop it silently, or to finish it with an error response. It holds two lock bits in the always-on debug reset domain. The software lock stops software from changing debug settings while the external debugger keeps full write access. The OS lock fences off the registers that live in the core power domain while an operating system saves or restores them. Accesses to core-domain registers are also refused while the core reports that it is powered down.

The gate owns three small registers of its own:
- A key register. Writing the unlock key releases the software lock, and any other value sets it.
- A status register that reports both locks.
- An OS-lock control register.

Every other offset goes to the bank through a plain combinational register interface. The bank answers with a hit flag, a core-domain flag and read data for the address it is shown. APB has no valid/ready stream here. PREADY is always high, so the gate never applies back-pressure, and every transfer completes in its first access phase.

Top module: `dbg_access_gate`

## Requirements
- R1: While the software lock is set, a write to a bank register with PADDR[31]=0 (software) produces no bank write strobe and no PSLVERR. Reads from the bank still proceed and return bank data.
- R2: A transfer with PADDR[31]=1 (external debugger) ignores the software lock. Its writes reach the bank and the OS-lock register as they would with the lock clear.
- R3: While the OS lock is set, any read or write to a bank register whose core-domain flag is 1 sets PSLVERR and strobes neither bank_wr nor bank_rd.
- R4: While core_pwr_down is 1, any access to a bank register whose core-domain flag is 1 sets PSLVERR and strobes nothing.
- R5: Both locks reset to 0 on PRESETn low. They keep their value while core_pwr_down changes and change only through writes to the key or OS-lock register.
- R6: A write to offset 0xFB0 (PADDR[11:0]) with data 0xC5ACCE55 clears the software lock, and any other data sets it. This write is never dropped or refused. A read of offset 0xFB4 returns bit0 = software lock and bit1 = OS lock, with the other bits 0.
- R7: Offset 0x300 is the OS-lock register. Bit 0 of a write sets the OS lock. A read returns the lock in bit 0. It is never refused by the OS lock or by power-down. A software write to it is dropped while the software lock is set.
- R8: When several rules apply, the error takes precedence. A core-domain access that is refused for power-down or the OS lock returns PSLVERR even if it is also a software write under the software lock.
- R9: An offset that is neither gate-owned nor a bank hit returns PSLVERR if either lock is set. Otherwise it reads as 0, and writes to it are dropped without a strobe.
- R10: PREADY is always 1. bank_wr and bank_rd pulse only in an access phase (PSEL and PENABLE both 1), never together, and the bank sees a forwarded read's data on PRDATA in that same phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Debug-domain reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | 32 | Byte address; bit 31 marks the external debugger |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Error response |
| core_pwr_down | input | 1 | Core power domain is off |
| bank_addr | output | 10 | Word address shown to the bank (PADDR[11:2]) |
| bank_hit | input | 1 | Bank implements bank_addr |
| bank_core | input | 1 | bank_addr is in the core power domain |
| bank_wr | output | 1 | Bank write strobe |
| bank_rd | output | 1 | Bank read strobe |
| bank_wdata | output | 32 | Bank write data |
| bank_rdata | input | 32 | Bank read data for bank_addr |

## Verification
Three rules can apply to the same transfer: the power-down refusal, the OS-lock refusal and the software-lock drop. The bench provokes the collision on purpose. With both locks set and the core reported off, it issues a software write to a core-domain register, and it expects PSLVERR with no bank strobe rather than a silent drop. A second overlap is a debugger write under the software lock. That write must pass, while the same write from software is later shown, by reading the register back, to have left the register unchanged.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
  typedef enum logic [1:0] {
    VD_FORWARD = 2'd0,
    VD_DISCARD = 2'd1,
    VD_FAULT   = 2'd2,
    VD_LOCAL   = 2'd3
  } verdict_e;

  localparam logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55;
endpackage

// File: rtl/dbg_lock_regs.sv
module dbg_lock_regs
  import dbg_gate_pkg::*;
#(
  parameter int OFS_W    = 12,
  parameter int DATA_W   = 32,
  parameter logic [OFS_W-1:0] KEY_OFS  = 12'hFB0,
  parameter logic [OFS_W-1:0] STAT_OFS = 12'hFB4,
  parameter logic [OFS_W-1:0] OSL_OFS  = 12'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              wr,
  input  logic              from_dbg,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  output logic              sw_lock,
  output logic              os_lock,
  output logic              own_hit,
  output logic              own_drop,
  output logic [DATA_W-1:0] own_rdata
);
  logic hit_key, hit_stat, hit_osl;
  logic key_we, osl_we;

  assign hit_key  = (ofs == KEY_OFS);
  assign hit_stat = (ofs == STAT_OFS);
  assign hit_osl  = (ofs == OSL_OFS);
  assign own_hit  = hit_key | hit_stat | hit_osl;

  // software write to OS-lock register is dropped under software lock
  assign own_drop = hit_osl & wr & sw_lock & ~from_dbg;

  assign key_we = acc & wr & hit_key;
  assign osl_we = acc & wr & hit_osl & ~own_drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_lock <= 1'b0;
      os_lock <= 1'b0;
    end else begin
      if (key_we) sw_lock <= (wdata != DATA_W'(UNLOCK_KEY));
      if (osl_we) os_lock <= wdata[0];
    end
  end

  always_comb begin
    own_rdata = '0;
    if (hit_stat) begin
      own_rdata[0] = sw_lock;
      own_rdata[1] = os_lock;
    end else if (hit_osl) begin
      own_rdata[0] = os_lock;
    end
  end

  assert_locks_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_we || osl_we) |=> $stable({sw_lock, os_lock}));

  assert_key_unlock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr && hit_key && wdata == DATA_W'(UNLOCK_KEY)) |=> !sw_lock);

  assert_osl_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr && hit_osl && sw_lock && !from_dbg) |=> $stable(os_lock));
endmodule

// File: rtl/dbg_access_decide.sv
module dbg_access_decide
  import dbg_gate_pkg::*;
(
  input  logic     wr,
  input  logic     from_dbg,
  input  logic     own_hit,
  input  logic     own_drop,
  input  logic     bank_hit,
  input  logic     bank_core,
  input  logic     core_off,
  input  logic     sw_lock,
  input  logic     os_lock,
  output verdict_e verdict
);
  // priority: gate-owned, unmapped, core-domain refusal, software drop, pass
  always_comb begin
    if (own_hit)
      verdict = own_drop ? VD_DISCARD : VD_LOCAL;
    else if (!bank_hit)
      verdict = (sw_lock | os_lock) ? VD_FAULT : VD_DISCARD;
    else if (bank_core && (core_off || os_lock))
      verdict = VD_FAULT;
    else if (wr && sw_lock && !from_dbg)
      verdict = VD_DISCARD;
    else
      verdict = VD_FORWARD;
  end
endmodule

// File: rtl/dbg_access_gate.sv
module dbg_access_gate
  import dbg_gate_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int BANK_AW = 10,
  parameter logic [BANK_AW+1:0] KEY_OFS  = 12'hFB0,
  parameter logic [BANK_AW+1:0] STAT_OFS = 12'hFB4,
  parameter logic [BANK_AW+1:0] OSL_OFS  = 12'h300
) (
  input  logic               pclk,
  input  logic               presetn,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [DATA_W-1:0]  pwdata,
  output logic [DATA_W-1:0]  prdata,
  output logic               pready,
  output logic               pslverr,
  input  logic               core_pwr_down,
  output logic [BANK_AW-1:0] bank_addr,
  input  logic               bank_hit,
  input  logic               bank_core,
  output logic               bank_wr,
  output logic               bank_rd,
  output logic [DATA_W-1:0]  bank_wdata,
  input  logic [DATA_W-1:0]  bank_rdata
);
  localparam int OFS_W = BANK_AW + 2;

  logic              acc, from_dbg;
  logic [OFS_W-1:0]  ofs;
  logic              sw_lock, os_lock, own_hit, own_drop;
  logic [DATA_W-1:0] own_rdata;
  verdict_e          verdict;
  logic              unused_bits;

  assign acc         = psel & penable;
  assign from_dbg    = paddr[ADDR_W-1];
  assign ofs         = paddr[OFS_W-1:0];
  assign unused_bits = ^{paddr[ADDR_W-2:OFS_W], paddr[1:0]};

  dbg_lock_regs #(
    .OFS_W(OFS_W), .DATA_W(DATA_W),
    .KEY_OFS(KEY_OFS), .STAT_OFS(STAT_OFS), .OSL_OFS(OSL_OFS)
  ) u_locks (
    .clk(pclk), .rst_n(presetn), .acc(acc), .wr(pwrite),
    .from_dbg(from_dbg), .ofs(ofs), .wdata(pwdata),
    .sw_lock(sw_lock), .os_lock(os_lock), .own_hit(own_hit),
    .own_drop(own_drop), .own_rdata(own_rdata)
  );

  dbg_access_decide u_decide (
    .wr(pwrite), .from_dbg(from_dbg), .own_hit(own_hit), .own_drop(own_drop),
    .bank_hit(bank_hit), .bank_core(bank_core), .core_off(core_pwr_down),
    .sw_lock(sw_lock), .os_lock(os_lock), .verdict(verdict)
  );

  assign bank_addr  = paddr[OFS_W-1:2];
  assign bank_wdata = pwdata;
  assign bank_wr    = acc &  pwrite & (verdict == VD_FORWARD);
  assign bank_rd    = acc & ~pwrite & (verdict == VD_FORWARD);
  assign pslverr    = acc & (verdict == VD_FAULT);
  assign pready     = 1'b1;

  always_comb begin
    prdata = '0;
    if (!pwrite) begin
      if (verdict == VD_LOCAL)        prdata = own_rdata;
      else if (verdict == VD_FORWARD) prdata = bank_rdata;
    end
  end

  assert_swlock_drop_R1: assert property (@(posedge pclk) disable iff (!presetn)
    (acc && pwrite && sw_lock && !from_dbg && !own_hit) |-> !bank_wr);

  assert_fault_no_strobe_R3: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |-> !(bank_wr || bank_rd));

  assert_pwrdown_fault_R4: assert property (@(posedge pclk) disable iff (!presetn)
    (acc && !own_hit && bank_hit && bank_core && core_pwr_down) |-> pslverr);

  assert_strobe_phase_R10: assert property (@(posedge pclk) disable iff (!presetn)
    (bank_wr || bank_rd) |-> (acc && !(bank_wr && bank_rd)));
endmodule

// File: tb/tb_dbg_access_gate.sv
module tb_dbg_access_gate;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'hC5AC_CE55;
  localparam logic [31:0] DBG = 32'h8000_0000;

  logic        pclk = 1'b0, presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [31:0] paddr = '0, pwdata = '0, prdata;
  logic        pready, pslverr, core_pwr_down = 1'b0;
  logic [9:0]  bank_addr;
  logic        bank_hit, bank_core, bank_wr, bank_rd;
  logic [31:0] bank_wdata, bank_rdata;

  logic [31:0] bank_mem [16] = '{default: 32'h0};
  logic [31:0] exp_mem  [16] = '{default: 32'h0};
  bit exp_sw = 0, exp_os = 0, finished = 0;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) pclk = ~pclk;

  // bench bank: 16 words at 0x000..0x03C, upper half in core domain
  assign bank_hit   = (bank_addr < 10'd16);
  assign bank_core  = bank_addr[3];
  assign bank_rdata = bank_hit ? bank_mem[bank_addr[3:0]] : 32'h0;
  always @(posedge pclk) if (bank_wr) bank_mem[bank_addr[3:0]] <= bank_wdata;

  dbg_access_gate dut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // every clock: strobes only in access phase, pready high
  always @(negedge pclk) begin
    #2;
    if (presetn && !finished) begin
      check("R10", {31'h0, pready}, 32'h1);
      if (!(psel && penable)) check("R10", {30'h0, bank_wr, bank_rd}, 32'h0);
    end
  end

  // reference model: 0 pass, 1 drop, 2 error, 3 local
  task automatic xfer(string tag, bit wr, logic [31:0] addr, logic [31:0] data);
    int kind; logic [31:0] rexp; int idx; bit dbg;
    logic [11:0] ofs;
    ofs = addr[11:0]; dbg = addr[31]; idx = int'(addr[11:2]); rexp = 0;
    if (ofs == 12'hFB0) kind = 3;
    else if (ofs == 12'hFB4) begin kind = 3; rexp = {30'h0, exp_os, exp_sw}; end
    else if (ofs == 12'h300) begin
      kind = (wr && exp_sw && !dbg) ? 1 : 3; rexp = {31'h0, exp_os};
    end
    else if (idx >= 16) kind = (exp_sw || exp_os) ? 2 : 1;
    else if (idx >= 8 && (core_pwr_down || exp_os)) kind = 2;
    else if (wr && exp_sw && !dbg) kind = 1;
    else begin kind = 0; rexp = exp_mem[idx]; end

    @(negedge pclk);
    psel = 1; pwrite = wr; paddr = addr; pwdata = data;
    @(negedge pclk);
    penable = 1;
    #1;
    check(tag, {31'h0, pslverr}, {31'h0, kind == 2});
    check(tag, {31'h0, bank_wr}, {31'h0, wr && kind == 0});
    if (!wr) check(tag, prdata, rexp);
    if (wr && kind == 3 && ofs == 12'hFB0) exp_sw = (data != KEY);
    if (wr && kind == 3 && ofs == 12'h300) exp_os = data[0];
    if (wr && kind == 0) exp_mem[idx] = data;
    @(negedge pclk);
    psel = 0; penable = 0;
  endtask

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1;
    xfer("R5", 0, 32'hFB4, 0);               // reset state: both locks clear
    xfer("R10", 1, 32'h000, 32'h1111_0000);
    xfer("R10", 1, 32'h004, 32'h2222_0000);
    xfer("R10", 1, 32'h024, 32'h9999_0000);  // core-domain word 9
    xfer("R10", 0, 32'h024, 0);
    xfer("R6", 1, 32'hFB0, 32'h1234_5678);   // wrong key locks
    xfer("R6", 0, 32'hFB4, 0);
    xfer("R1", 1, 32'h004, 32'hDEAD_0001);   // dropped
    xfer("R1", 0, 32'h004, 0);               // unchanged, read works
    xfer("R2", 1, DBG | 32'h004, 32'hB00B_0002);
    xfer("R2", 0, 32'h004, 0);
    xfer("R7", 1, 32'h300, 32'h1);           // software: dropped
    xfer("R7", 0, 32'h300, 0);
    xfer("R2", 1, DBG | 32'h300, 32'h1);     // debugger sets OS lock
    xfer("R7", 0, 32'h300, 0);
    xfer("R3", 0, 32'h024, 0);               // core read refused
    xfer("R3", 1, DBG | 32'h024, 32'h5);     // core write refused
    xfer("R3", 0, 32'h008, 0);               // debug-domain word fine
    xfer("R9", 1, 32'h100, 32'h7);           // unmapped, locked
    xfer("R9", 0, 32'h100, 0);
    core_pwr_down = 1;
    xfer("R8", 1, 32'h028, 32'hAAAA_AAAA);   // all three rules collide
    xfer("R7", 0, 32'h300, 0);               // OS-lock reg reachable while off
    xfer("R5", 0, 32'hFB4, 0);               // locks kept while off
    xfer("R6", 1, 32'hFB0, KEY);             // unlock software lock
    xfer("R7", 1, 32'h300, 32'h0);           // clear OS lock
    xfer("R4", 0, 32'h024, 0);               // still refused: powered down
    xfer("R4", 1, 32'h02C, 32'h3);
    xfer("R4", 0, 32'h00C, 0);               // debug-domain word allowed
    core_pwr_down = 0;
    xfer("R4", 0, 32'h024, 0);               // reachable again
    xfer("R9", 0, 32'h100, 0);               // unmapped, unlocked: zero
    xfer("R9", 1, 32'h104, 32'h5);           // dropped, no error
    xfer("R6", 1, 32'hFB0, 32'h0);
    xfer("R2", 1, DBG | 32'h300, 32'h1);
    xfer("R5", 0, 32'hFB4, 0);
    @(negedge pclk); presetn = 0;
    exp_sw = 0; exp_os = 0;
    @(negedge pclk); presetn = 1;
    xfer("R5", 0, 32'hFB4, 0);               // reset clears both
    xfer("R10", 0, 32'h028, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge pclk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule